// File: doc/BRIEF.md
# ADC Gain-Ranging Controller with Dwell Hysteresis

This block watches a stream of two's-complement ADC samples and produces a 3-bit gain code for an external gain-ranging stage that sits in front of the converter. The magnitude of each valid sample is compared against a programmable upper limit and a programmable lower limit. A sample that is too large steps the gain code down at once, so the converter does not clip. A sample that is too small arms a dwell timer. The code steps up only once the signal has stayed under the lower limit for the whole programmed dwell time. Each code step stands for 6.02 dB, so the seven steps of the code cover 42 dB.

The same three pins can also serve as exponent inputs. A single enable input chooses the use: with the enable low the block drives nothing, holds its code at zero and clears its timer. This is also the state after reset, so the block cannot fight another driver. The block brings out a registered output-enable for the pad drivers.

Top module: `gain_range_ctrl`

## Requirements
- R1: After reset the gain code is 0, the output-enable is 0 and no dwell wait is pending.
- R2: The output-enable follows the enable input one clock later. While the enable is 0, valid samples have no effect: the gain code is forced to 0 and any dwell wait is dropped.
- R3: Comparisons use the absolute value of the sample. The most negative sample, -2^(DATA_W-1), has magnitude 2^(DATA_W-1).
- R4: A valid sample whose magnitude is strictly greater than the upper limit lowers the gain code by 1. The new code appears on the clock edge that takes that sample.
- R5: A decrement when the gain code is 0 leaves the code at 0.
- R6: With dwell setting D (D = 0 acts as 1), a run of valid samples with magnitude strictly below the lower limit raises the code by 1 on the (D+1)-th sample of the run. The first sample of the run loads the timer with D, and each later sample counts it down.
- R7: While the run of below-limit samples continues, the code keeps rising by 1 every further D samples.
- R8: An increment when the gain code is 7 leaves the code at 7.
- R9: A valid sample whose magnitude lies within [lower, upper] ends a pending dwell wait without changing the code. The next below-limit sample starts a full new wait.
- R10: A valid above-limit sample during a dwell wait ends the wait and decrements the code.
- R11: A sample that is both above the upper limit and below the lower limit is treated as above the upper limit.
- R12: Cycles with the valid strobe low neither change the gain code nor advance the dwell timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| gain_en | input | 1 | 1: pins carry the gain code; 0: pins are exponent inputs, block idle |
| smp_valid | input | 1 | Qualifies smp_data on this cycle |
| smp_data | input | DATA_W | Two's-complement ADC sample |
| thr_upper | input | DATA_W | Upper magnitude limit (unsigned) |
| thr_lower | input | DATA_W | Lower magnitude limit (unsigned) |
| dwell_len | input | DWELL_W | Dwell time in valid samples |
| gain_code | output | 3 | Gain-ranging code, 0 to 7 |
| gain_oe | output | 1 | Output-enable for the shared pins |

## Verification
The hardest situation to reach from the ports is a dwell wait that is cut short exactly one sample before it would expire. The timer is internal, so only the exact count of samples sent tells whether it sits at 1. The bench therefore sends precisely D below-limit samples, then an in-band, above-limit or strobe-low cycle. It expects the code to stay unchanged until a full D+1 further samples have arrived. Sweeping D from 0 to 4 across the full 0-to-7 ramp also covers the reload after each step and the saturation at the top of the code.

// File: rtl/gr_pkg.sv
package gr_pkg;

  typedef enum logic [1:0] {
    CMP_INBAND = 2'd0,
    CMP_BELOW  = 2'd1,
    CMP_ABOVE  = 2'd2
  } gr_cmp_e;

endpackage

// File: rtl/gr_rst_sync.sv
module gr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_ns = sync_q[STAGES-1];

endmodule

// File: rtl/gr_mag_cmp.sv
module gr_mag_cmp
  import gr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] smp_data,
  input  logic [DATA_W-1:0] thr_upper,
  input  logic [DATA_W-1:0] thr_lower,
  output gr_cmp_e           cls
);

  logic [DATA_W-1:0] mag;
  logic              is_above;
  logic              is_below;

  // magnitude of a two's-complement value; -2^(W-1) maps to 2^(W-1)
  always_comb begin
    if (smp_data[DATA_W-1]) begin
      mag = (~smp_data) + {{(DATA_W-1){1'b0}}, 1'b1};
    end else begin
      mag = smp_data;
    end
  end

  assign is_above = (mag > thr_upper);
  assign is_below = (mag < thr_lower);

  // upper limit wins when both hold (misprogrammed limits)
  always_comb begin
    if (is_above) begin
      cls = CMP_ABOVE;
    end else if (is_below) begin
      cls = CMP_BELOW;
    end else begin
      cls = CMP_INBAND;
    end
  end

endmodule

// File: rtl/gr_dwell_timer.sv
module gr_dwell_timer
  import gr_pkg::*;
#(
  parameter int DWELL_W = 20
) (
  input  logic               clk,
  input  logic               rst_ns,
  input  logic               clr,
  input  logic               step_en,
  input  gr_cmp_e            cls,
  input  logic [DWELL_W-1:0] dwell_len,
  output logic               expire
);

  localparam logic [DWELL_W-1:0] CNT_ONE = DWELL_W'(1);

  logic               armed_q, armed_d;
  logic [DWELL_W-1:0] cnt_q, cnt_d;
  logic               at_end;

  assign at_end = (cnt_q <= CNT_ONE);
  assign expire = !clr && step_en && (cls == CMP_BELOW) && armed_q && at_end;

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    if (clr) begin
      armed_d = 1'b0;
      cnt_d   = '0;
    end else if (step_en) begin
      if (cls == CMP_BELOW) begin
        if (!armed_q) begin
          armed_d = 1'b1;
          cnt_d   = dwell_len;
        end else if (at_end) begin
          cnt_d   = dwell_len;
        end else begin
          cnt_d   = cnt_q - CNT_ONE;
        end
      end else begin
        armed_d = 1'b0;
        cnt_d   = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
    end
  end

  // R6
  // dwell_count_chk: a running wait counts down by one per below-limit sample
  dwell_count_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (!clr && step_en && cls == CMP_BELOW && armed_q && !at_end)
      |=> (armed_q && cnt_q == $past(cnt_q) - CNT_ONE));

  // R9
  // dwell_abort_chk: any non-below valid sample drops the wait
  dwell_abort_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (!clr && step_en && cls != CMP_BELOW) |=> !armed_q);

  // R12
  // dwell_hold_chk: strobe-low cycles leave the timer untouched
  dwell_hold_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (!clr && !step_en) |=> ($stable(cnt_q) && $stable(armed_q)));

endmodule

// File: rtl/gr_code_stepper.sv
module gr_code_stepper #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_ns,
  input  logic              clr,
  input  logic              dec_req,
  input  logic              inc_req,
  output logic [CODE_W-1:0] code
);

  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] CODE_ONE = CODE_W'(1);

  logic [CODE_W-1:0] code_q, code_d;

  always_comb begin
    code_d = code_q;
    if (clr) begin
      code_d = '0;
    end else if (dec_req) begin
      if (code_q != '0) begin
        code_d = code_q - CODE_ONE;
      end
    end else if (inc_req) begin
      if (code_q != CODE_MAX) begin
        code_d = code_q + CODE_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      code_q <= '0;
    end else begin
      code_q <= code_d;
    end
  end

  assign code = code_q;

  // R4
  // code_dec_chk: an above-limit sample lowers a nonzero code by one
  code_dec_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (!clr && dec_req && code_q != '0) |=> (code_q == $past(code_q) - CODE_ONE));

  // R5
  // code_floor_chk: code stays at zero on a decrement
  code_floor_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (!clr && dec_req && code_q == '0) |=> (code_q == '0));

  // R8
  // code_ceil_chk: code stays at the top on an increment
  code_ceil_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (!clr && !dec_req && inc_req && code_q == CODE_MAX) |=> (code_q == CODE_MAX));

  // R7
  // code_step_chk: without a clear the code moves by at most one
  code_step_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    !clr |=> (code_q == $past(code_q) || code_q == $past(code_q) + CODE_ONE ||
              code_q == $past(code_q) - CODE_ONE));

endmodule

// File: rtl/gain_range_ctrl.sv
module gain_range_ctrl
  import gr_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int DWELL_W = 20,
  parameter int CODE_W  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               gain_en,
  input  logic               smp_valid,
  input  logic [DATA_W-1:0]  smp_data,
  input  logic [DATA_W-1:0]  thr_upper,
  input  logic [DATA_W-1:0]  thr_lower,
  input  logic [DWELL_W-1:0] dwell_len,
  output logic [CODE_W-1:0]  gain_code,
  output logic               gain_oe
);

  logic    rst_ns;
  gr_cmp_e cls;
  logic    clr;
  logic    expire;
  logic    dec_req;
  logic    oe_q, oe_d;

  gr_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  gr_mag_cmp #(.DATA_W(DATA_W)) u_cmp (
    .smp_data  (smp_data),
    .thr_upper (thr_upper),
    .thr_lower (thr_lower),
    .cls       (cls)
  );

  assign clr     = !gain_en;
  assign dec_req = smp_valid && (cls == CMP_ABOVE);

  gr_dwell_timer #(.DWELL_W(DWELL_W)) u_dwell (
    .clk       (clk),
    .rst_ns    (rst_ns),
    .clr       (clr),
    .step_en   (smp_valid),
    .cls       (cls),
    .dwell_len (dwell_len),
    .expire    (expire)
  );

  gr_code_stepper #(.CODE_W(CODE_W)) u_step (
    .clk     (clk),
    .rst_ns  (rst_ns),
    .clr     (clr),
    .dec_req (dec_req),
    .inc_req (expire),
    .code    (gain_code)
  );

  assign oe_d = gain_en;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      oe_q <= 1'b0;
    end else begin
      oe_q <= oe_d;
    end
  end

  assign gain_oe = oe_q;

  // R2
  // idle_code_chk: whenever the pins are not driven the code sits at zero
  idle_code_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    !gain_oe |-> (gain_code == '0));

  // R2
  // oe_follow_chk: output-enable tracks the enable one cycle later
  oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    gain_en |=> gain_oe);

endmodule

// File: tb/gain_range_ctrl_tb_top.sv
module gain_range_ctrl_tb_top;

  localparam int DATA_W  = 16;
  localparam int DWELL_W = 20;
  localparam int CODE_W  = 3;

  logic               clk;
  logic               rst_n;
  logic               gain_en;
  logic               smp_valid;
  logic [DATA_W-1:0]  smp_data;
  logic [DATA_W-1:0]  thr_upper;
  logic [DATA_W-1:0]  thr_lower;
  logic [DWELL_W-1:0] dwell_len;
  logic [CODE_W-1:0]  gain_code;
  logic               gain_oe;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 0;

  localparam logic [DATA_W-1:0] S_LOW_P  = 16'sd10;
  localparam logic [DATA_W-1:0] S_LOW_N  = -16'sd10;
  localparam logic [DATA_W-1:0] S_BAND   = 16'sd500;
  localparam logic [DATA_W-1:0] S_HIGH_P = 16'sd2000;
  localparam logic [DATA_W-1:0] S_HIGH_N = -16'sd2000;
  localparam logic [DATA_W-1:0] S_MOSTN  = 16'h8000;

  gain_range_ctrl #(.DATA_W(DATA_W), .DWELL_W(DWELL_W), .CODE_W(CODE_W)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .gain_en   (gain_en),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .thr_upper (thr_upper),
    .thr_lower (thr_lower),
    .dwell_len (dwell_len),
    .gain_code (gain_code),
    .gain_oe   (gain_oe)
  );

  // 125 MHz
  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below 20000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  // starts and ends at a falling edge; one rising edge in between
  task automatic send(input logic [DATA_W-1:0] d, input logic v);
    smp_data  = d;
    smp_valid = v;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic idle_clear();
    gain_en = 1'b0;
    send(S_BAND, 1'b0);
    gain_en = 1'b1;
    send(S_BAND, 1'b0);
  endtask

  initial begin
    rst_n     = 1'b0;
    gain_en   = 1'b0;
    smp_valid = 1'b0;
    smp_data  = '0;
    thr_upper = 16'd1000;
    thr_lower = 16'd100;
    dwell_len = 20'd3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 code", int'(gain_code), 0);
    chk("R1 oe", int'(gain_oe), 0);

    // R2 disabled: below samples ignored
    for (int i = 0; i < 10; i++) send(S_LOW_P, 1'b1);
    chk("R2 code while disabled", int'(gain_code), 0);
    chk("R2 oe while disabled", int'(gain_oe), 0);
    gain_en = 1'b1;
    send(S_BAND, 1'b0);
    chk("R2 oe after enable", int'(gain_oe), 1);

    // R6 R7 R8 R3: ramp sweep over dwell settings, signs alternate
    for (int d = 0; d <= 4; d++) begin
      int deff;
      deff = (d == 0) ? 1 : d;
      dwell_len = DWELL_W'(d);
      idle_clear();
      for (int k = 1; k <= 7 * deff + 3; k++) begin
        int e;
        send((k % 2) ? S_LOW_N : S_LOW_P, 1'b1);
        e = (k - 1) / deff;
        if (e > 7) e = 7;
        chk($sformatf("R6/R7/R8 ramp d=%0d k=%0d", d, k), int'(gain_code), e);
      end
    end

    // R4 R5 R3: decrement from 7 to 0, including the most negative sample
    for (int k = 1; k <= 9; k++) begin
      int e;
      send((k % 3 == 0) ? S_MOSTN : ((k % 2) ? S_HIGH_N : S_HIGH_P), 1'b1);
      e = 7 - k;
      if (e < 0) e = 0;
      chk($sformatf("R4/R5/R3 down k=%0d", k), int'(gain_code), e);
    end

    // R2 disable clears a raised code
    dwell_len = 20'd1;
    send(S_LOW_P, 1'b1);
    send(S_LOW_P, 1'b1);
    send(S_LOW_P, 1'b1);
    chk("R2 code raised", int'(gain_code), 2);
    gain_en = 1'b0;
    send(S_LOW_P, 1'b1);
    chk("R2 code cleared", int'(gain_code), 0);
    chk("R2 oe dropped", int'(gain_oe), 0);
    gain_en = 1'b1;
    send(S_BAND, 1'b0);

    // R9: in-band sample one step before expiry restarts the wait
    dwell_len = 20'd3;
    for (int i = 0; i < 3; i++) send(S_LOW_P, 1'b1);
    send(S_BAND, 1'b1);
    chk("R9 no step after band", int'(gain_code), 0);
    for (int i = 0; i < 3; i++) send(S_LOW_P, 1'b1);
    chk("R9 wait restarted", int'(gain_code), 0);
    send(S_LOW_P, 1'b1);
    chk("R9 step after full wait", int'(gain_code), 1);

    // R10: above sample during a wait aborts it and decrements
    send(S_BAND, 1'b1);
    for (int i = 0; i < 3; i++) send(S_LOW_N, 1'b1);
    send(S_HIGH_P, 1'b1);
    chk("R10 decrement", int'(gain_code), 0);
    for (int i = 0; i < 3; i++) send(S_LOW_N, 1'b1);
    chk("R10 wait restarted", int'(gain_code), 0);
    send(S_LOW_N, 1'b1);
    chk("R10 step after full wait", int'(gain_code), 1);

    // R11: sample both above upper and below lower counts as above
    thr_lower = 16'd5000;
    send(S_HIGH_P, 1'b1);
    chk("R11 upper wins", int'(gain_code), 0);
    thr_lower = 16'd100;
    send(S_BAND, 1'b1);

    // R12: strobe-low cycles do not advance the timer
    dwell_len = 20'd2;
    send(S_LOW_P, 1'b1);
    for (int i = 0; i < 5; i++) send(S_LOW_P, 1'b0);
    chk("R12 no change while idle", int'(gain_code), 0);
    send(S_LOW_P, 1'b1);
    chk("R12 one more sample", int'(gain_code), 0);
    send(S_LOW_P, 1'b1);
    chk("R12 step on third sample", int'(gain_code), 1);

    // R3: most negative sample is above, not below
    send(S_MOSTN, 1'b1);
    chk("R3 most negative decrements", int'(gain_code), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule